// File: doc/BRIEF.md
# Configurable Timer Counter Core

This block is a free-running timer/counter whose counting width, clock division, direction, stop behaviour and per-channel roles are all set by static configuration inputs. A tick input qualifies the clock. A prescaler divides those ticks by a chosen ratio, and the counter advances once for each divided tick. The counter counts up from zero, or down from its TOP value. Every wrap raises a one-cycle strobe. In one-shot mode the counter freezes after its first wrap until it is restarted.

Each channel works in one of two roles. As a compare channel it drives a waveform output. As a capture channel it latches the counter value on a rising edge of its input. Each channel has an invert control that flips its output pin, or its input pin when it captures. TOP is the all-ones value of the selected width. In match-frequency mode, TOP is instead the compare value of channel 0, and channel 0 then toggles its output at each wrap. A restart input reloads the start value. Whether that reload happens on the next clock or on the next divided tick is a configuration choice.

Software must hold `run` low while it changes the configuration, and for at least two cycles before raising `run` again.

Top module: `tmr_core`

## Requirements
- R1: The width code `cfg_width` selects the counter width: 2'b01 gives 8 bits, 2'b10 gives 32 bits, and 2'b00 or 2'b11 gives 16 bits. Counter bits above the selected width always read zero. All compares use only the selected width.
- R2: The prescaler code `cfg_presc` values 0 through 7 select the division ratios 1, 2, 4, 8, 16, 64, 256 and 1024. After `run` rises, the counter advances on the last cycle of every group of that many cycles with `tick_in` high.
- R3: When counting up, the counter steps by one and moves from TOP to 0. In the cycle it shows 0 after that wrap, `ovf` is high for exactly that cycle.
- R4: When counting down (`cfg_down`=1), the counter starts from TOP, steps down by one, and moves from 0 back to TOP. In the cycle it shows TOP after that wrap, `ovf` is high.
- R5: TOP is the all-ones value of the selected width. When `cfg_mfrq`=1, TOP is instead `cmp_val` of channel 0 (bits 31:0), truncated to the selected width.
- R6: With `cfg_oneshot`=1, the counter holds its value after the first wrap. Further ticks do not change it until a restart or until `run` is dropped.
- R7: With `cfg_psync`=0, a `restart` pulse loads the start value (0 up, TOP down) on the next clock edge, clears the prescaler and clears the one-shot stop.
- R8: With `cfg_psync`=1, a `restart` pulse is held pending. The counter loads the start value at the next prescaled advance, in place of counting, and the prescaler keeps its phase.
- R9: A compare channel drives `wave_out` as (count < its compare value) XOR its invert bit. In match-frequency mode, channel 0 instead toggles at every wrap, starting from 0, and is then XORed with its invert bit.
- R10: A channel with its bit set in `cfg_capen` latches the count on each rising edge of (`cap_in` XOR invert bit). The latched value appears on `cap_val` together with a one-cycle `cap_vld`, one clock after the edge is sampled. The channel's `wave_out` then equals its invert bit.
- R11: While `run` is low, the counter holds the start value, `ovf` stays low, and the prescaler and the one-shot stop are cleared. After reset, `count` is 0 and `ovf` and `cap_vld` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | Counter enable; low holds the start value |
| restart | input | 1 | Single-cycle reload request |
| tick_in | input | 1 | Prescaler tick source |
| cfg_width | input | 2 | Width code (01=8, 10=32, else 16) |
| cfg_presc | input | 3 | Prescaler ratio code |
| cfg_psync | input | 1 | 0: restart on next clock, 1: on next prescaled tick |
| cfg_down | input | 1 | Count direction down |
| cfg_oneshot | input | 1 | Stop after the first wrap |
| cfg_mfrq | input | 1 | Match-frequency mode, TOP from channel 0 |
| cfg_capen | input | NCH | Per-channel capture enable |
| cfg_inv | input | NCH | Per-channel pin inversion |
| cmp_val | input | NCH*32 | Compare values, channel n at bits 32n+31:32n |
| cap_in | input | NCH | Capture inputs |
| wave_out | output | NCH | Waveform outputs |
| ovf | output | 1 | One-cycle wrap strobe |
| count | output | 32 | Counter value |
| cap_val | output | NCH*32 | Captured values, channel n at bits 32n+31:32n |
| cap_vld | output | NCH | One-cycle capture strobes |

## Verification
The embedded assertions check several invariants on every cycle:
- the prescaler phase never passes its limit;
- the upper counter bits stay clear;
- a wrap strobe always pairs with the right wrap value for the direction;
- a stopped one-shot counter stays still;
- capture strobes come only from capture-enabled channels, and the captured value stays stable between strobes.

Only the bench's scenarios can show the rest: the exact division ratios, the delayed reload under the synchronized restart, the compare polarity against chosen thresholds, and the captured values at the right count. The bench shows these by comparing every output, every cycle, against an independent cycle model under random configurations, and by adding directed cases at the wrap and restart boundaries.

// File: rtl/tmr_pkg.sv
// Package: shared types and decode functions for the timer counter core.
// Assumes the counter is at most CNT_W bits wide and the prescaler at most PSC_W bits.
package tmr_pkg;
    localparam int CNT_W = 32;
    localparam int PSC_W = 10;

    typedef logic [CNT_W-1:0] cnt_t;
    typedef logic [PSC_W-1:0] psc_t;

    typedef enum logic [1:0] {
        WID_16 = 2'b00,
        WID_8  = 2'b01,
        WID_32 = 2'b10,
        WID_RS = 2'b11
    } wid_e;

    // Mask of the active counter bits for a width code.
    function automatic cnt_t width_mask(input logic [1:0] code);
        case (wid_e'(code))
            WID_8:   width_mask = cnt_t'(8'hFF);
            WID_32:  width_mask = '1;
            default: width_mask = cnt_t'(16'hFFFF);
        endcase
    endfunction

    // Terminal phase (ratio minus one) of the prescaler for a ratio code.
    function automatic psc_t presc_limit(input logic [2:0] code);
        case (code)
            3'd0:    presc_limit = psc_t'(0);
            3'd1:    presc_limit = psc_t'(1);
            3'd2:    presc_limit = psc_t'(3);
            3'd3:    presc_limit = psc_t'(7);
            3'd4:    presc_limit = psc_t'(15);
            3'd5:    presc_limit = psc_t'(63);
            3'd6:    presc_limit = psc_t'(255);
            default: presc_limit = psc_t'(1023);
        endcase
    endfunction
endpackage

// File: rtl/tmr_presc.sv
// Module: tick divider. Counts qualified ticks and flags the last tick of each group.
// Assumes the ratio code is static while run is high; clr restarts the phase.
module tmr_presc
    import tmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       clr,
    input  logic       tick_in,
    input  logic [2:0] code,
    output logic       adv
);
    psc_t phase;
    psc_t lim;

    // Decode the terminal phase from the ratio code.
    always_comb lim = presc_limit(code);

    // Advance request on the tick that completes a group.
    assign adv = run && tick_in && (phase == lim);

    // Phase counter: cleared when idle or on an immediate restart.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || clr) begin
            phase <= '0;
        end else if (tick_in) begin
            phase <= (phase == lim) ? '0 : phase + psc_t'(1);
        end
    end

    p_phase_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(run) |-> (phase <= lim));
endmodule

// File: rtl/tmr_cnt.sv
// Module: counter state machine with direction, wrap strobe, one-shot stop and restart.
// Assumes mask and top are static while run is high and top is already masked.
module tmr_cnt
    import tmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic adv,
    input  logic restart,
    input  logic psync,
    input  logic down,
    input  logic oneshot,
    input  cnt_t mask,
    input  cnt_t top,
    output cnt_t count,
    output logic ovf,
    output logic wrap_tgl
);
    cnt_t start;
    logic stopped;
    logic pend;

    // Start value depends on the counting direction.
    always_comb start = down ? top : '0;

    // Counter update with restart priority, pending reload and wrap handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0; ovf <= 1'b0; stopped <= 1'b0; pend <= 1'b0; wrap_tgl <= 1'b0;
        end else if (!run) begin
            count <= start; ovf <= 1'b0; stopped <= 1'b0; pend <= 1'b0; wrap_tgl <= 1'b0;
        end else begin
            ovf <= 1'b0;
            if (restart && !psync) begin
                count <= start; stopped <= 1'b0; pend <= 1'b0;
            end else if ((restart || pend) && adv) begin
                count <= start; stopped <= 1'b0; pend <= 1'b0;
            end else begin
                if (restart) pend <= 1'b1;
                if (adv && !stopped) begin
                    if (!down) begin
                        if (count >= top) begin
                            count <= '0; ovf <= 1'b1; wrap_tgl <= ~wrap_tgl; stopped <= oneshot;
                        end else begin
                            count <= (count + cnt_t'(1)) & mask;
                        end
                    end else begin
                        if (count == '0) begin
                            count <= top; ovf <= 1'b1; wrap_tgl <= ~wrap_tgl; stopped <= oneshot;
                        end else begin
                            count <= (count - cnt_t'(1)) & mask;
                        end
                    end
                end
            end
        end
    end

    p_upper_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(run) |-> ((count & ~mask) == '0));
    p_wrap_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !down) |-> (count == '0));
    p_wrap_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && down) |-> (count == top));
    p_oneshot_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && stopped && !restart && !pend) |=> $stable(count));
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (!ovf && !stopped && !pend));
endmodule

// File: rtl/tmr_chan.sv
// Module: one channel, either a compare output or an edge-triggered capture latch.
// Assumes the role, invert bit and compare value are static while run is high.
module tmr_chan
    import tmr_pkg::*;
#(
    parameter bit IS_TOP_CH = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  cnt_t count,
    input  cnt_t mask,
    input  cnt_t cmp,
    input  logic mfrq,
    input  logic wrap_tgl,
    input  logic capen,
    input  logic inv,
    input  logic cap_in,
    output logic wave,
    output cnt_t cap_val,
    output logic cap_vld
);
    logic eff_in;
    logic eff_prev;
    logic raw;

    // Pin-side inversion of the capture input.
    always_comb eff_in = cap_in ^ inv;

    // Raw waveform: idle for capture, toggle for the TOP channel in match mode, else compare.
    always_comb begin
        if (capen)                  raw = 1'b0;
        else if (IS_TOP_CH && mfrq) raw = wrap_tgl;
        else                        raw = (count < (cmp & mask));
    end

    assign wave = raw ^ inv;

    // Edge detect and latch of the count on a rising effective input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eff_prev <= 1'b0; cap_val <= '0; cap_vld <= 1'b0;
        end else begin
            eff_prev <= eff_in;
            cap_vld  <= 1'b0;
            if (capen && eff_in && !eff_prev) begin
                cap_val <= count;
                cap_vld <= 1'b1;
            end
        end
    end

    p_capvld_role_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cap_vld |-> $past(capen));
    p_capval_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_vld |-> $stable(cap_val));
    p_cap_pin_r10: assert property (@(posedge clk) disable iff (!rst_n)
        capen |-> (wave == inv));
endmodule

// File: rtl/tmr_core.sv
// Module: top of the timer counter core; decodes width and TOP, wires prescaler,
// counter and one channel instance per channel. Assumes configuration is static while run is high.
module tmr_core
    import tmr_pkg::*;
#(
    parameter int NCH = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               restart,
    input  logic               tick_in,
    input  logic [1:0]         cfg_width,
    input  logic [2:0]         cfg_presc,
    input  logic               cfg_psync,
    input  logic               cfg_down,
    input  logic               cfg_oneshot,
    input  logic               cfg_mfrq,
    input  logic [NCH-1:0]     cfg_capen,
    input  logic [NCH-1:0]     cfg_inv,
    input  logic [NCH*32-1:0]  cmp_val,
    input  logic [NCH-1:0]     cap_in,
    output logic [NCH-1:0]     wave_out,
    output logic               ovf,
    output logic [31:0]        count,
    output logic [NCH*32-1:0]  cap_val,
    output logic [NCH-1:0]     cap_vld
);
    cnt_t mask;
    cnt_t top;
    cnt_t cnt_q;
    logic adv;
    logic tgl;
    logic psc_clr;

    // Active-bit mask and wrap value from the configuration.
    always_comb begin
        mask = width_mask(cfg_width);
        top  = cfg_mfrq ? (cnt_t'(cmp_val[31:0]) & mask) : mask;
    end

    // An immediate restart also clears the prescaler phase.
    assign psc_clr = restart && !cfg_psync;

    tmr_presc u_presc (
        .clk(clk), .rst_n(rst_n), .run(run), .clr(psc_clr),
        .tick_in(tick_in), .code(cfg_presc), .adv(adv)
    );

    tmr_cnt u_cnt (
        .clk(clk), .rst_n(rst_n), .run(run), .adv(adv), .restart(restart),
        .psync(cfg_psync), .down(cfg_down), .oneshot(cfg_oneshot),
        .mask(mask), .top(top), .count(cnt_q), .ovf(ovf), .wrap_tgl(tgl)
    );

    assign count = 32'(cnt_q);

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        tmr_chan #(.IS_TOP_CH(g == 0)) u_chan (
            .clk(clk), .rst_n(rst_n), .count(cnt_q), .mask(mask),
            .cmp(cnt_t'(cmp_val[g*32 +: 32])), .mfrq(cfg_mfrq), .wrap_tgl(tgl),
            .capen(cfg_capen[g]), .inv(cfg_inv[g]), .cap_in(cap_in[g]),
            .wave(wave_out[g]), .cap_val(cap_val[g*32 +: 32]), .cap_vld(cap_vld[g])
        );
    end
endmodule

// File: tb/tmr_core_tb.sv
// Bench: directed corner cases followed by seeded random configurations, every cycle
// compared against an independent cycle model of the requirements.
module tmr_core_tb_top;
    localparam int NCH = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              run = 1'b0, restart = 1'b0, tick_in = 1'b0;
    logic [1:0]        cfg_width = 2'b00;
    logic [2:0]        cfg_presc = 3'd0;
    logic              cfg_psync = 1'b0, cfg_down = 1'b0, cfg_oneshot = 1'b0, cfg_mfrq = 1'b0;
    logic [NCH-1:0]    cfg_capen = '0, cfg_inv = '0, cap_in = '0;
    logic [NCH*32-1:0] cmp_val = '0;
    logic [NCH-1:0]    wave_out, cap_vld;
    logic              ovf;
    logic [31:0]       count;
    logic [NCH*32-1:0] cap_val;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    tmr_core #(.NCH(NCH)) dut_i (
        .clk(clk), .rst_n(rst_n), .run(run), .restart(restart), .tick_in(tick_in),
        .cfg_width(cfg_width), .cfg_presc(cfg_presc), .cfg_psync(cfg_psync),
        .cfg_down(cfg_down), .cfg_oneshot(cfg_oneshot), .cfg_mfrq(cfg_mfrq),
        .cfg_capen(cfg_capen), .cfg_inv(cfg_inv), .cmp_val(cmp_val), .cap_in(cap_in),
        .wave_out(wave_out), .ovf(ovf), .count(count), .cap_val(cap_val), .cap_vld(cap_vld)
    );

    // Requirement-derived helpers.
    function automatic logic [31:0] f_mask(input logic [1:0] w);
        if (w == 2'b01)      return 32'hFF;
        else if (w == 2'b10) return 32'hFFFF_FFFF;
        else                 return 32'hFFFF;
    endfunction

    function automatic int f_ratio(input logic [2:0] c);
        case (c)
            3'd0: return 1;   3'd1: return 2;   3'd2: return 4;   3'd3: return 8;
            3'd4: return 16;  3'd5: return 64;  3'd6: return 256; default: return 1024;
        endcase
    endfunction

    function automatic logic [31:0] f_top();
        return cfg_mfrq ? (cmp_val[31:0] & f_mask(cfg_width)) : f_mask(cfg_width);
    endfunction

    // Independent cycle model.
    int          m_ph;
    logic [31:0] m_c;
    logic        m_ovf, m_stop, m_pend, m_tgl;
    logic [NCH-1:0] m_prev, m_vld;
    logic [31:0] m_cv [NCH];

    always @(posedge clk) begin
        logic [31:0] tp, st, mk;
        logic        adv;
        mk = f_mask(cfg_width);
        tp = f_top();
        st = cfg_down ? tp : 32'd0;
        adv = run && tick_in && (m_ph == f_ratio(cfg_presc) - 1);
        for (int i = 0; i < NCH; i++) begin
            logic e;
            e = cap_in[i] ^ cfg_inv[i];
            if (!rst_n) begin
                m_prev[i] <= 1'b0; m_vld[i] <= 1'b0; m_cv[i] <= '0;
            end else begin
                m_prev[i] <= e;
                m_vld[i]  <= cfg_capen[i] && e && !m_prev[i];
                if (cfg_capen[i] && e && !m_prev[i]) m_cv[i] <= m_c;
            end
        end
        if (!rst_n) begin
            m_ph <= 0; m_c <= 0; m_ovf <= 0; m_stop <= 0; m_pend <= 0; m_tgl <= 0;
        end else if (!run) begin
            m_ph <= 0; m_c <= st; m_ovf <= 0; m_stop <= 0; m_pend <= 0; m_tgl <= 0;
        end else begin
            if (restart && !cfg_psync) m_ph <= 0;
            else if (tick_in) m_ph <= (m_ph == f_ratio(cfg_presc) - 1) ? 0 : m_ph + 1;
            m_ovf <= 0;
            if (restart && !cfg_psync) begin
                m_c <= st; m_stop <= 0; m_pend <= 0;
            end else if ((restart || m_pend) && adv) begin
                m_c <= st; m_stop <= 0; m_pend <= 0;
            end else begin
                if (restart) m_pend <= 1;
                if (adv && !m_stop) begin
                    if (!cfg_down && m_c >= tp) begin
                        m_c <= 0; m_ovf <= 1; m_tgl <= ~m_tgl; m_stop <= cfg_oneshot;
                    end else if (cfg_down && m_c == 0) begin
                        m_c <= tp; m_ovf <= 1; m_tgl <= ~m_tgl; m_stop <= cfg_oneshot;
                    end else begin
                        m_c <= (cfg_down ? m_c - 1 : m_c + 1) & mk;
                    end
                end
            end
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Compare every output against the model; called away from the clock edge.
    task automatic model_cmp();
        check("R3 count", count, m_c);
        check("R3 ovf", ovf, m_ovf);
        for (int i = 0; i < NCH; i++) begin
            logic r;
            if (cfg_capen[i]) r = 1'b0;
            else if (i == 0 && cfg_mfrq) r = m_tgl;
            else r = (m_c < (cmp_val[i*32 +: 32] & f_mask(cfg_width)));
            check("R9 wave", wave_out[i], r ^ cfg_inv[i]);
            check("R10 vld", cap_vld[i], m_vld[i]);
            check("R10 val", cap_val[i*32 +: 32], m_cv[i]);
        end
    endtask

    task automatic step(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            @(negedge clk);
            model_cmp();
        end
    endtask

    task automatic idle_cfg(input logic [1:0] w, input logic [2:0] p, input logic ps,
                            input logic dn, input logic os, input logic mf);
        run = 0; restart = 0;
        step(1);
        cfg_width = w; cfg_presc = p; cfg_psync = ps; cfg_down = dn;
        cfg_oneshot = os; cfg_mfrq = mf;
        step(2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1;
        step(1);
        check("R11 reset count", count, 0);
        check("R11 reset ovf", ovf, 0);
        check("R11 reset vld", cap_vld, 0);

        // 8-bit up wrap, ratio 1
        tick_in = 1;
        idle_cfg(2'b01, 3'd0, 0, 0, 0, 0);
        run = 1;
        step(255);
        check("R1 8-bit top", count, 255);
        step(1);
        check("R3 wrap to 0", count, 0);
        check("R3 ovf high", ovf, 1);
        step(1);
        check("R3 ovf one cycle", ovf, 0);

        // ratio 8
        idle_cfg(2'b01, 3'd3, 0, 0, 0, 0);
        run = 1;
        step(7);
        check("R2 ratio8 before", count, 0);
        step(1);
        check("R2 ratio8 advance", count, 1);

        // 16-bit down
        idle_cfg(2'b00, 3'd0, 0, 1, 0, 0);
        check("R4 idle at top", count, 32'hFFFF);
        check("R11 idle ovf", ovf, 0);
        run = 1;
        step(2);
        check("R4 decrement", count, 32'hFFFD);

        // match-frequency one-shot, immediate restart
        cmp_val[31:0] = 32'd5;
        idle_cfg(2'b01, 3'd0, 0, 0, 1, 1);
        run = 1;
        step(5);
        check("R5 reach cmp0", count, 5);
        step(1);
        check("R5 wrap at cmp0", count, 0);
        check("R5 ovf at cmp0", ovf, 1);
        step(4);
        check("R6 stopped", count, 0);
        restart = 1; step(1); restart = 0;
        check("R7 restart load", count, 0);
        step(3);
        check("R7 counting again", count, 3);
        restart = 1; step(1); restart = 0;
        check("R7 mid restart", count, 0);

        // synchronized restart, ratio 4
        idle_cfg(2'b01, 3'd2, 1, 0, 0, 0);
        run = 1;
        step(12);
        check("R8 pre count", count, 3);
        restart = 1; step(1); restart = 0;
        step(2);
        check("R8 pending hold", count, 3);
        step(1);
        check("R8 load on tick", count, 0);

        // compare polarity
        cmp_val = {32'd10, 32'd0};
        cfg_inv = 2'b10;
        idle_cfg(2'b01, 3'd0, 0, 0, 0, 0);
        run = 1;
        step(5);
        check("R9 inverted below", wave_out[1], 0);
        check("R9 ch0 cmp0", wave_out[0], 0);
        step(10);
        check("R9 inverted above", wave_out[1], 1);

        // capture
        cfg_capen = 2'b01;
        cfg_inv = 2'b00;
        step(2);
        begin
            logic [31:0] c;
            c = count;
            cap_in[0] = 1; step(1);
            check("R10 capture vld", cap_vld[0], 1);
            check("R10 capture value", cap_val[31:0], c);
            step(1);
            check("R10 vld pulse", cap_vld[0], 0);
            cfg_inv = 2'b01; step(2);
            check("R10 capture pin inv", wave_out[0], 1);
            c = count;
            cap_in[0] = 0; step(1);
            check("R10 inverted edge value", cap_val[31:0], c);
        end

        // random segments
        for (int s = 0; s < 8; s++) begin
            cfg_capen = 2'($urandom);
            cfg_inv = 2'($urandom);
            cmp_val = {32'($urandom_range(0, 400)), 32'($urandom_range(1, 300))};
            idle_cfg(2'($urandom), 3'($urandom_range(0, 4)), 1'($urandom), 1'($urandom),
                     1'($urandom_range(0, 3) == 0), 1'($urandom));
            run = 1;
            for (int k = 0; k < 1500; k++) begin
                tick_in = ($urandom_range(0, 9) < 8);
                restart = ($urandom_range(0, 99) < 2);
                if ($urandom_range(0, 19) == 0) cap_in = 2'($urandom);
                step(1);
            end
            restart = 0;
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule